// File: doc/BRIEF.md
# Fractional-N Ratio Selection Path

This block produces the 32-bit control word that steers a fractional-N clock synthesizer. Software loads four multiplier ratios and one control register over a simple write/read port. The block picks one stored ratio, aligns it to a common fixed-point format, and can scale it by a power of two. It then compensates the ratio for the divider in front of the reference input. The result, called the effective ratio, goes out as the target for an external digital PLL.

The synthesizer word is either the effective ratio (static source) or the ratio that the digital PLL returns (dynamic source). Software picks the source with a bit, or lets a presence detector choose it. The detector watches the frequency-reference clock and selects the dynamic source while that clock is toggling. The slot index comes from a separate field in each source mode. In dynamic mode, stored ratios may be read in either of two fixed-point formats.

Top module: `fracn_ratio_path`

## Requirements
- R1: Addresses 0 to 3 hold ratio slots 0 to 3 (32 bits each, written and read back unchanged). Address 4 holds the 13-bit control register, which reads back with bits 31:13 as zero. Writes to addresses 5 to 7 change nothing, and reads from them return zero.
- R2: Control layout: bits 1:0 static index, 3:2 lock index, 6:4 modifier code, 7 modifier enable, 9:8 divider setting, 10 low-frequency format, 11 manual dynamic select, 12 automatic source. The static index picks the slot when the static source is in use. The lock index picks it when the dynamic source is in use.
- R3: The output format is unsigned 20.12. A slot read as 12.20 is shifted right by 8 bits. The static source always reads slots as 12.20. The dynamic source reads them as 12.20 when bit 10 is 0 and uses them unchanged as 20.12 when bit 10 is 1.
- R4: When bit 7 is set, the modifier code works as follows: 000 leaves the ratio unchanged, 001/010/011 shift left by 1/2/3, and 100/101/110/111 shift right by 1/2/3/4. When bit 7 is clear, the code has no effect.
- R5: Any left shift whose result does not fit in 32 bits gives 0xFFFFFFFF.
- R6: The divider setting shifts the modified ratio left: 00 by 0, 01 by 1, 10 by 2. The setting 11 acts as 00.
- R7: `target_o` carries the effective ratio in every source mode.
- R8: While the static source is in use, `fracn_o` equals the effective ratio.
- R9: While the dynamic source is in use, `fracn_o` equals `dpll_ratio_i` as sampled on the previous clock edge.
- R10: When bit 12 is 0, bit 11 chooses the source (1 = dynamic). When bit 12 is 1, the dynamic source is used exactly when the reference clock is detected as present, and bit 11 is ignored.
- R11: The reference clock is detected as present after 16 rising edges, with no gap of 1024 system cycles between them. It is detected as absent after 1024 system cycles with no rising edge. `ref_present_o` changes only on a detected edge (rising) or a timeout (falling).
- R12: `fracn_o`, `target_o` and `src_dyn_o` are registered and follow their inputs one cycle later. After reset every output, register and slot is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ref_clk_in | input | 1 | Frequency-reference clock, sampled by `clk` |
| dpll_ratio_i | input | 32 | Ratio returned by the digital PLL, 20.12 |
| fracn_o | output | 32 | Synthesizer control word, 20.12 |
| target_o | output | 32 | Effective ratio sent to the digital PLL |
| src_dyn_o | output | 1 | 1 when the dynamic source drives `fracn_o` |
| ref_present_o | output | 1 | Reference clock detected as present |

## Verification
The ratio path is combinational and sits between two register stages. A wrong index, format, shift or saturation therefore shows up in `target_o` one edge after the control write takes effect, with no hidden state to mask it. A wrong source decision shows up on the same edge, because `fracn_o` drops away from `target_o` or from `dpll_ratio_i`. The presence detector is the only state that builds up over time. A wrong edge count or timeout only shows up after the full 16-edge or 1024-cycle window, so the checks sample just past both windows and well inside them.

// File: rtl/fracn_ratio_pkg.sv
package fracn_ratio_pkg;

    localparam int RATIO_W    = 32;
    localparam int NUM_SLOTS  = 4;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int ADDR_W     = 3;
    localparam int FMT_SHIFT  = 8;   // 12.20 -> 20.12 alignment
    localparam int SAT_GUARD  = 4;   // headroom bits for left shifts up to 3

    typedef struct packed {
        logic                  auto_src;
        logic                  man_dyn;
        logic                  lf_fmt;
        logic [1:0]            ref_div;
        logic                  mod_en;
        logic [2:0]            mod_sel;
        logic [SLOT_IDX_W-1:0] lock_idx;
        logic [SLOT_IDX_W-1:0] stat_idx;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SLOTS);

    typedef logic [NUM_SLOTS-1:0][RATIO_W-1:0] slot_arr_t;

    typedef struct packed {
        slot_arr_t slots;
        ctrl_t     ctrl;
    } cfg_state_t;

    typedef struct packed {
        logic [RATIO_W-1:0] fracn;
        logic [RATIO_W-1:0] target;
        logic               src_dyn;
    } out_state_t;

endpackage

// File: rtl/fracn_cfg_regs.sv
module fracn_cfg_regs
    import fracn_ratio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [RATIO_W-1:0]  wdata,
    output logic [RATIO_W-1:0]  rdata,
    output slot_arr_t           slots_o,
    output ctrl_t               ctrl_o
);

    cfg_state_t st_d, st_q;
    logic [NUM_SLOTS-1:0] slot_hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
        assign slot_hit[g] = (addr == ADDR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (slot_hit[i]) st_d.slots[i] = wdata;
            end
            if (addr == CTRL_ADDR) st_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_hit[i]) rdata = st_q.slots[i];
        end
        if (addr == CTRL_ADDR) rdata = {{(RATIO_W-CTRL_W){1'b0}}, st_q.ctrl};
    end

    assign slots_o = st_q.slots;
    assign ctrl_o  = st_q.ctrl;

endmodule

// File: rtl/fracn_ref_detect.sv
module fracn_ref_detect #(
    parameter int ABSENT_CYCLES = 1024,
    parameter int PRESENT_EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk_in,
    output logic edge_o,
    output logic present_o
);

    localparam int IDLE_W = $clog2(ABSENT_CYCLES + 1);
    localparam int EDGE_W = $clog2(PRESENT_EDGES + 1);

    typedef struct packed {
        logic [2:0]        sync;      // two sync stages plus previous sample
        logic [IDLE_W-1:0] idle_cnt;
        logic [EDGE_W-1:0] edge_cnt;
        logic              present;
    } det_state_t;

    det_state_t st_d, st_q;

    assign edge_o = st_q.sync[1] & ~st_q.sync[2];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], ref_clk_in};
        if (edge_o) begin
            st_d.idle_cnt = '0;
            if (!st_q.present) begin
                if (st_q.edge_cnt == EDGE_W'(PRESENT_EDGES - 1)) begin
                    st_d.present  = 1'b1;
                    st_d.edge_cnt = '0;
                end else begin
                    st_d.edge_cnt = st_q.edge_cnt + 1'b1;
                end
            end
        end else if (st_q.idle_cnt == IDLE_W'(ABSENT_CYCLES - 1)) begin
            st_d.present  = 1'b0;
            st_d.edge_cnt = '0;
        end else begin
            st_d.idle_cnt = st_q.idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign present_o = st_q.present;

endmodule

// File: rtl/fracn_ratio_calc.sv
module fracn_ratio_calc
    import fracn_ratio_pkg::*;
(
    input  slot_arr_t          slots_i,
    input  ctrl_t              ctrl_i,
    input  logic               dyn_i,
    output logic [RATIO_W-1:0] eff_o
);

    function automatic logic [RATIO_W-1:0] shl_sat(logic [RATIO_W-1:0] x, logic [1:0] k);
        logic [RATIO_W+SAT_GUARD-1:0] w;
        w = {{SAT_GUARD{1'b0}}, x} << k;
        return (|w[RATIO_W+SAT_GUARD-1:RATIO_W]) ? '1 : w[RATIO_W-1:0];
    endfunction

    logic [SLOT_IDX_W-1:0] idx;
    logic [RATIO_W-1:0]    raw, aligned, modded;
    logic [2:0]            rsh;
    logic [1:0]            div_sh;

    always_comb begin
        idx     = dyn_i ? ctrl_i.lock_idx : ctrl_i.stat_idx;
        raw     = slots_i[idx];
        aligned = (dyn_i && ctrl_i.lf_fmt) ? raw : (raw >> FMT_SHIFT);

        rsh    = {1'b0, ctrl_i.mod_sel[1:0]} + 3'd1;
        modded = aligned;
        if (ctrl_i.mod_en) begin
            if (ctrl_i.mod_sel[2])             modded = aligned >> rsh;
            else if (ctrl_i.mod_sel[1:0] != 0) modded = shl_sat(aligned, ctrl_i.mod_sel[1:0]);
        end

        div_sh = (ctrl_i.ref_div == 2'b11) ? 2'b00 : ctrl_i.ref_div;
        eff_o  = shl_sat(modded, div_sh);
    end

endmodule

// File: rtl/fracn_ratio_path.sv
module fracn_ratio_path
    import fracn_ratio_pkg::*;
#(
    parameter int ABSENT_CYCLES = 1024,
    parameter int PRESENT_EDGES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [RATIO_W-1:0] reg_wdata,
    output logic [RATIO_W-1:0] reg_rdata,
    input  logic               ref_clk_in,
    input  logic [RATIO_W-1:0] dpll_ratio_i,
    output logic [RATIO_W-1:0] fracn_o,
    output logic [RATIO_W-1:0] target_o,
    output logic               src_dyn_o,
    output logic               ref_present_o
);

    slot_arr_t          slots;
    ctrl_t              ctrl;
    logic               ref_edge;
    logic               ref_present;
    logic               sel_dyn;
    logic [RATIO_W-1:0] eff;
    out_state_t         out_d, out_q;

    fracn_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .slots_o (slots),
        .ctrl_o  (ctrl)
    );

    fracn_ref_detect #(
        .ABSENT_CYCLES (ABSENT_CYCLES),
        .PRESENT_EDGES (PRESENT_EDGES)
    ) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_clk_in (ref_clk_in),
        .edge_o     (ref_edge),
        .present_o  (ref_present)
    );

    assign sel_dyn = ctrl.auto_src ? ref_present : ctrl.man_dyn;

    fracn_ratio_calc u_calc (
        .slots_i (slots),
        .ctrl_i  (ctrl),
        .dyn_i   (sel_dyn),
        .eff_o   (eff)
    );

    always_comb begin
        out_d         = out_q;
        out_d.src_dyn = sel_dyn;
        out_d.target  = eff;
        out_d.fracn   = sel_dyn ? dpll_ratio_i : eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fracn_o       = out_q.fracn;
    assign target_o      = out_q.target;
    assign src_dyn_o     = out_q.src_dyn;
    assign ref_present_o = ref_present;

endmodule

// File: rtl/fracn_ratio_path_chk.sv
module fracn_ratio_path_chk
    import fracn_ratio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] fracn_o,
    input logic [RATIO_W-1:0] target_o,
    input logic [RATIO_W-1:0] dpll_ratio_i,
    input logic               src_dyn_o,
    input logic               ref_present_o,
    input logic               auto_src,
    input logic               ref_edge
);

    a_r8_static_matches_target: assert property (@(posedge clk) disable iff (!rst_n)
        !src_dyn_o |-> (fracn_o == target_o));

    a_r9_dynamic_follows_dpll: assert property (@(posedge clk) disable iff (!rst_n)
        src_dyn_o |-> (fracn_o == $past(dpll_ratio_i)));

    a_r10_auto_tracks_presence: assert property (@(posedge clk) disable iff (!rst_n)
        $past(auto_src) |-> (src_dyn_o == $past(ref_present_o)));

    a_r11_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_present_o) |-> $past(ref_edge));

    a_r11_fall_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_present_o) |-> !$past(ref_edge));

endmodule

bind fracn_ratio_path fracn_ratio_path_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fracn_o       (fracn_o),
    .target_o      (target_o),
    .dpll_ratio_i  (dpll_ratio_i),
    .src_dyn_o     (src_dyn_o),
    .ref_present_o (ref_present_o),
    .auto_src      (ctrl.auto_src),
    .ref_edge      (ref_edge)
);

// File: tb/fracn_ratio_path_tb.sv
module fracn_ratio_path_tb_top;

    localparam logic [31:0] DPLL_A = 32'h1234_5678;
    localparam logic [31:0] DPLL_B = 32'hABCD_0000;
    localparam int NVEC = 15;

    // {control word, expected fracn_o, expected target_o}
    localparam logic [95:0] VECS [NVEC] = '{
        {32'h0000_0000, 32'h0000_1000, 32'h0000_1000}, // R2 R3 slot0 static
        {32'h0000_0001, 32'h0000_3000, 32'h0000_3000}, // R2 slot1
        {32'h0000_0091, 32'h0000_6000, 32'h0000_6000}, // R4 x2
        {32'h0000_0011, 32'h0000_3000, 32'h0000_3000}, // R4 code ignored when disabled
        {32'h0000_00E0, 32'h0000_0200, 32'h0000_0200}, // R4 /8
        {32'h0000_00F0, 32'h0000_0100, 32'h0000_0100}, // R4 /16
        {32'h0000_0102, 32'h0000_0300, 32'h0000_0300}, // R6 div 2
        {32'h0000_0202, 32'h0000_0600, 32'h0000_0600}, // R6 div 4
        {32'h0000_0302, 32'h0000_0180, 32'h0000_0180}, // R6 setting 11
        {32'h0000_02A0, 32'h0001_0000, 32'h0001_0000}, // R4 R6 x4 then div 4
        {32'h0000_040E, 32'h0000_0180, 32'h0000_0180}, // R3 format bit ignored in static
        {32'h0000_0809, DPLL_A,        32'h0000_0180}, // R2 R9 lock index, 12.20
        {32'h0000_0C09, DPLL_A,        32'h0001_8000}, // R3 20.12 dynamic
        {32'h0000_0C9C, DPLL_A,        32'hFFFF_FFFF}, // R5 modifier saturates
        {32'h0000_0E0C, DPLL_A,        32'hFFFF_FFFF}  // R5 R6 correction saturates
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ref_clk_in = 1'b0;
    logic [31:0] dpll_ratio_i = DPLL_A;
    logic [31:0] fracn_o, target_o;
    logic        src_dyn_o, ref_present_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fracn_ratio_path dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ref_clk_in    (ref_clk_in),
        .dpll_ratio_i  (dpll_ratio_i),
        .fracn_o       (fracn_o),
        .target_o      (target_o),
        .src_dyn_o     (src_dyn_o),
        .ref_present_o (ref_present_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_ref(int n);
        for (int i = 0; i < n; i++) begin
            ref_clk_in = 1'b1; repeat (2) @(negedge clk);
            ref_clk_in = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        check("R12 reset fracn", fracn_o, 32'h0);
        check("R12 reset target", target_o, 32'h0);
        check("R12 reset src", {31'h0, src_dyn_o}, 32'h0);
        rst_n = 1'b1;
        rd(3'd2, rv);
        check("R12 reset slot", rv, 32'h0);

        wr(3'd0, 32'h0010_0000);
        wr(3'd1, 32'h0030_0000);
        wr(3'd2, 32'h0001_8000);
        wr(3'd3, 32'hFFF0_0000);
        rd(3'd1, rv); check("R1 slot1 readback", rv, 32'h0030_0000);
        rd(3'd3, rv); check("R1 slot3 readback", rv, 32'hFFF0_0000);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, rv); check("R1 ctrl readback", rv, 32'h0000_1FFF);
        wr(3'd5, 32'hDEAD_BEEF);
        rd(3'd5, rv); check("R1 unmapped read", rv, 32'h0);
        rd(3'd0, rv); check("R1 unmapped write harmless", rv, 32'h0010_0000);

        for (int v = 0; v < NVEC; v++) begin
            wr(3'd4, VECS[v][95:64]);
            settle();
            check($sformatf("R7 R8 R9 vector %0d fracn", v), fracn_o, VECS[v][63:32]);
            check($sformatf("R7 vector %0d target", v), target_o, VECS[v][31:0]);
            check($sformatf("R10 vector %0d source", v), {31'h0, src_dyn_o}, {31'h0, VECS[v][75]});
        end

        // R12 one-cycle latency of dynamic word
        @(negedge clk) dpll_ratio_i = DPLL_B;
        @(negedge clk);
        check("R12 R9 dpll latency", fracn_o, DPLL_B);
        dpll_ratio_i = DPLL_A;

        // R10 automatic mode with reference absent: manual bit ignored
        wr(3'd4, 32'h0000_1804);
        settle();
        check("R10 auto absent source", {31'h0, src_dyn_o}, 32'h0);
        check("R10 auto absent fracn", fracn_o, 32'h0000_1000);

        // R11 fewer than 16 edges: still absent
        pulse_ref(12);
        settle();
        check("R11 12 edges absent", {31'h0, ref_present_o}, 32'h0);
        pulse_ref(8);
        settle();
        check("R11 present after 16 edges", {31'h0, ref_present_o}, 32'h1);
        check("R10 auto present source", {31'h0, src_dyn_o}, 32'h1);
        check("R10 auto present fracn", fracn_o, DPLL_A);
        check("R2 lock index in auto dynamic", target_o, 32'h0000_3000);

        repeat (900) @(negedge clk);
        check("R11 held within window", {31'h0, ref_present_o}, 32'h1);
        repeat (200) @(negedge clk);
        check("R11 absent after timeout", {31'h0, ref_present_o}, 32'h0);
        check("R10 back to static", {31'h0, src_dyn_o}, 32'h0);
        check("R8 static word after loss", fracn_o, 32'h0000_1000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule